// File: doc/BRIEF.md
# Posted-Write I/O Bus Slave Port

This controller sits between a fast processor bus and a slower I/O bus. Each processor access to I/O space arrives as a one-clock start pulse with a direction bit and two byte-lane strobes. The controller latches these into one of two slots and asks an external I/O bus master to run the cycle. It uses a request output and an acknowledge input for this handshake. Every transfer moves through a fixed sequence of sequencer states: idle (0), request (3), wait-acknowledge (2), wait-finish (1), and back to idle.

Writes are posted. The processor is told it may proceed as soon as a slot holds its write, so a second write can queue behind the first. That second write may arrive even before the master has acknowledged the first. Reads are not posted. Their ready indication is a single-clock pulse given only after the I/O cycle has finished. A combined ready output picks the read or write indication according to the address of the current access.

Top module: `iob_posted_port`

## Requirements
- R1: After reset, `io_req_o` is 0, `ale_n_o` is 2'b11 (both slots free), `wr_rdy_o` is 1 and `rd_rdy_o` is 0.
- R2: A start pulse seen in the idle state raises `io_req_o` in the next cycle. In that same cycle the slot that took the access has its latch-enable bit low (bit 0 = slot 0, bit 1 = slot 1). `io_rd_o`, `io_uds_o` and `io_lds_o` show the captured direction (1 = read) and strobes.
- R3: `io_req_o` stays high while `io_act_i` is sampled low. In the cycle after `io_act_i` is sampled high, `io_req_o` is low and the served slot's latch-enable bit has returned high.
- R4: For a read, `rd_rdy_o` is high for exactly one cycle, the cycle after `io_act_i` is sampled low in the wait-finish state. For a write it stays low.
- R5: `wr_rdy_o` is low exactly while both slots are occupied.
- R6: A second start pulse one clock after the first is accepted into slot 1. Queued work is served oldest first: once the first cycle finishes, `io_req_o` rises again with the second access's fields.
- R7: A start pulse while both slots are occupied is ignored: no slot is overwritten and no extra transfer is made.
- R8: `rdy_o` equals `rd_rdy_o` when `addr_i` lies within [RD_LO, RD_HI] inclusive, and equals `wr_rdy_o` otherwise.
- R9: After the acknowledge, `io_req_o` does not rise again while `io_act_i` is still high.
- R10: When both slots are empty, a new access always goes to slot 0, even if slot 1 served the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-clock pulse marking a new I/O access |
| dir_rd_i | input | 1 | Direction of the access, 1 = read |
| uds_i | input | 1 | Upper byte-lane strobe of the access |
| lds_i | input | 1 | Lower byte-lane strobe of the access |
| addr_i | input | AW | Address of the current processor access, used for ready selection |
| io_act_i | input | 1 | Acknowledge/busy from the I/O bus master |
| io_req_o | output | 1 | Transfer request to the I/O bus master |
| io_rd_o | output | 1 | Direction of the slot being served |
| io_uds_o | output | 1 | Upper strobe of the slot being served |
| io_lds_o | output | 1 | Lower strobe of the slot being served |
| ale_n_o | output | 2 | Active-low latch-enable per slot, low while the slot is occupied |
| rd_rdy_o | output | 1 | Read completion pulse |
| wr_rdy_o | output | 1 | Write may be posted |
| rdy_o | output | 1 | Ready selected by address range |

## Verification
A wrong slot-valid bit shows up at once on the latch-enable outputs. It also shows on write-ready in the cycle after the capture or release. The bench compares both against the expected occupancy at every step of the two-write and overflow cases. A wrong oldest-slot pointer or a lost queue entry appears one transfer later. The second request then carries the wrong strobes, or it never rises. The bench therefore checks the fields on the re-raised request and the slot used once the buffer empties. A sequencer that skips the wait-finish state gives a read-ready pulse in the wrong cycle, or lets the request rise again while the acknowledge is high. The single-read case and the checker observe this within one cycle.

// File: rtl/iob_pkg.sv
package iob_pkg;
  localparam int NSLOT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DONE = 2'd1,
    ST_WAIT = 2'd2,
    ST_REQ  = 2'd3
  } iob_state_e;

  typedef struct packed {
    logic rd;
    logic uds;
    logic lds;
  } iob_slot_t;
endpackage

// File: rtl/iob_rst_sync.sv
module iob_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/iob_slot_store.sv
module iob_slot_store
  import iob_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_req_i,
  input  iob_slot_t         fields_i,
  input  logic              free_head_i,
  output logic [NSLOT-1:0]  valid_o,
  output logic              head_valid_o,
  output iob_slot_t         head_o
);
  logic [NSLOT-1:0] valid_q, valid_d;
  logic             head_q, head_d;
  logic             full, take, tgt;
  iob_slot_t        slot_q [NSLOT];

  assign full = &valid_q;
  assign take = take_req_i & ~full;
  // empty -> slot 0; one occupied -> the other one
  assign tgt  = valid_q[0];

  always_comb begin
    valid_d = valid_q;
    if (free_head_i) valid_d[head_q] = 1'b0;
    if (take)        valid_d[tgt]    = 1'b1;
  end

  always_comb begin
    head_d = head_q;
    if (free_head_i)        head_d = valid_d[~head_q] ? ~head_q : 1'b0;
    else if (valid_q == '0) head_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      head_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      head_q  <= head_d;
    end
  end

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    logic load;
    assign load = take & (tgt == gi[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[gi] <= '0;
      else if (load) slot_q[gi] <= fields_i;
    end
  end

  assign valid_o      = valid_q;
  assign head_valid_o = valid_q[head_q];
  assign head_o       = slot_q[head_q];
endmodule

// File: rtl/iob_seq_fsm.sv
module iob_seq_fsm
  import iob_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic head_valid_i,
  input  logic head_rd_i,
  input  logic io_act_i,
  output logic io_req_o,
  output logic free_head_o,
  output logic rd_rdy_o
);
  iob_state_e state_q, state_d;
  logic       cur_rd_q, rd_pulse_q, rd_pulse_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i | head_valid_i) state_d = ST_REQ;
      ST_REQ:  state_d = io_act_i ? ST_DONE : ST_WAIT;
      ST_WAIT: if (io_act_i) state_d = ST_DONE;
      ST_DONE: if (!io_act_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign io_req_o    = (state_q == ST_REQ) | (state_q == ST_WAIT);
  assign free_head_o = io_req_o & io_act_i;
  assign rd_pulse_d  = (state_q == ST_DONE) & ~io_act_i & cur_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rd_pulse_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_pulse_q <= rd_pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cur_rd_q <= 1'b0;
    else if (free_head_o) cur_rd_q <= head_rd_i;
  end

  assign rd_rdy_o = rd_pulse_q;
endmodule

// File: rtl/iob_rdy_mux.sv
module iob_rdy_mux #(
  parameter int          AW    = 8,
  parameter logic [AW-1:0] RD_LO = 8'h40,
  parameter logic [AW-1:0] RD_HI = 8'h7F
) (
  input  logic [AW-1:0] addr_i,
  input  logic          rd_rdy_i,
  input  logic          wr_rdy_i,
  output logic          rdy_o
);
  logic in_rd_range;
  assign in_rd_range = (addr_i >= RD_LO) && (addr_i <= RD_HI);
  assign rdy_o = in_rd_range ? rd_rdy_i : wr_rdy_i;
endmodule

// File: rtl/iob_posted_port.sv
module iob_posted_port
  import iob_pkg::*;
#(
  parameter int            AW    = 8,
  parameter logic [AW-1:0] RD_LO = 8'h40,
  parameter logic [AW-1:0] RD_HI = 8'h7F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          dir_rd_i,
  input  logic          uds_i,
  input  logic          lds_i,
  input  logic [AW-1:0] addr_i,
  input  logic          io_act_i,
  output logic          io_req_o,
  output logic          io_rd_o,
  output logic          io_uds_o,
  output logic          io_lds_o,
  output logic [1:0]    ale_n_o,
  output logic          rd_rdy_o,
  output logic          wr_rdy_o,
  output logic          rdy_o
);
  logic             rst_n_s;
  logic [NSLOT-1:0] valid;
  logic             head_valid, free_head;
  iob_slot_t        fields, head;

  iob_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign fields = '{rd: dir_rd_i, uds: uds_i, lds: lds_i};

  iob_slot_store u_store (
    .clk(clk), .rst_n(rst_n_s),
    .take_req_i(start_i), .fields_i(fields), .free_head_i(free_head),
    .valid_o(valid), .head_valid_o(head_valid), .head_o(head)
  );

  iob_seq_fsm u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .start_i(start_i), .head_valid_i(head_valid), .head_rd_i(head.rd),
    .io_act_i(io_act_i), .io_req_o(io_req_o), .free_head_o(free_head),
    .rd_rdy_o(rd_rdy_o)
  );

  iob_rdy_mux #(.AW(AW), .RD_LO(RD_LO), .RD_HI(RD_HI)) u_mux (
    .addr_i(addr_i), .rd_rdy_i(rd_rdy_o), .wr_rdy_i(wr_rdy_o), .rdy_o(rdy_o)
  );

  assign ale_n_o  = ~valid;
  assign wr_rdy_o = ~&valid;
  assign io_rd_o  = head.rd;
  assign io_uds_o = head.uds;
  assign io_lds_o = head.lds;
endmodule

// File: rtl/iob_posted_port_chk.sv
module iob_posted_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       io_act_i,
  input logic       io_req_o,
  input logic [1:0] ale_n_o,
  input logic       rd_rdy_o,
  input logic       wr_rdy_o
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && !io_act_i) |=> io_req_o);

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && io_act_i) |=> !io_req_o);

  p_rd_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rdy_o |=> !rd_rdy_o);

  p_rd_after_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rdy_o |-> ($past(!io_act_i) && $past(!io_req_o)));

  p_req_has_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_req_o) |-> (ale_n_o != 2'b11));

  p_wr_fall_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_rdy_o) |-> $past(start_i));

  p_no_rereq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_req_o && io_act_i) |=> !io_req_o);
endmodule

bind iob_posted_port iob_posted_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .io_act_i(io_act_i),
  .io_req_o(io_req_o), .ale_n_o(ale_n_o), .rd_rdy_o(rd_rdy_o),
  .wr_rdy_o(wr_rdy_o)
);

// File: tb/iob_posted_port_tb_top.sv
module iob_posted_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, dir_rd_i = 1'b0, uds_i = 1'b0, lds_i = 1'b0;
  logic [7:0] addr_i = 8'h10;
  logic       io_act_i = 1'b0;
  logic       io_req_o, io_rd_o, io_uds_o, io_lds_o, rd_rdy_o, wr_rdy_o, rdy_o;
  logic [1:0] ale_n_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  iob_posted_port #(.AW(8), .RD_LO(8'h40), .RD_HI(8'h7F)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i),
    .uds_i(uds_i), .lds_i(lds_i), .addr_i(addr_i), .io_act_i(io_act_i),
    .io_req_o(io_req_o), .io_rd_o(io_rd_o), .io_uds_o(io_uds_o),
    .io_lds_o(io_lds_o), .ale_n_o(ale_n_o), .rd_rdy_o(rd_rdy_o),
    .wr_rdy_o(wr_rdy_o), .rdy_o(rdy_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic launch(input logic rd, input logic u, input logic l);
    start_i = 1'b1; dir_rd_i = rd; uds_i = u; lds_i = l;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) nxt();
    rst_n = 1'b1;
    repeat (4) nxt();
    chk("R1 io_req", {7'd0, io_req_o}, 8'd0);
    chk("R1 ale_n", {6'd0, ale_n_o}, 8'd3);
    chk("R1 wr_rdy", {7'd0, wr_rdy_o}, 8'd1);
    chk("R1 rd_rdy", {7'd0, rd_rdy_o}, 8'd0);
  endtask

  task automatic t_single_write();
    launch(1'b0, 1'b1, 1'b0);
    nxt(); start_i = 1'b0;
    chk("R2 req raised", {7'd0, io_req_o}, 8'd1);
    chk("R2 slot0 latched", {6'd0, ale_n_o}, 8'd2);
    chk("R2 fields", {5'd0, io_rd_o, io_uds_o, io_lds_o}, 8'b010);
    chk("R5 one slot wr_rdy", {7'd0, wr_rdy_o}, 8'd1);
    nxt();
    chk("R3 req held", {7'd0, io_req_o}, 8'd1);
    io_act_i = 1'b1;
    nxt();
    chk("R3 req dropped", {7'd0, io_req_o}, 8'd0);
    chk("R3 slot released", {6'd0, ale_n_o}, 8'd3);
    nxt();
    chk("R9 no re-request while act high", {7'd0, io_req_o}, 8'd0);
    io_act_i = 1'b0;
    nxt();
    chk("R4 no pulse on write", {7'd0, rd_rdy_o}, 8'd0);
    nxt();
  endtask

  task automatic t_single_read();
    addr_i = 8'h50;
    launch(1'b1, 1'b1, 1'b1);
    nxt(); start_i = 1'b0;
    chk("R2 read fields", {5'd0, io_rd_o, io_uds_o, io_lds_o}, 8'b111);
    chk("R8 rdy follows rd_rdy", {7'd0, rdy_o}, 8'd0);
    addr_i = 8'h10; #1;
    chk("R8 rdy follows wr_rdy", {7'd0, rdy_o}, 8'd1);
    addr_i = 8'h7F; #1;
    chk("R8 upper bound in range", {7'd0, rdy_o}, 8'd0);
    nxt();
    io_act_i = 1'b1;
    nxt();
    chk("R4 no pulse while act high", {7'd0, rd_rdy_o}, 8'd0);
    io_act_i = 1'b0;
    nxt();
    chk("R4 read pulse", {7'd0, rd_rdy_o}, 8'd1);
    chk("R8 rdy shows read pulse", {7'd0, rdy_o}, 8'd1);
    nxt();
    chk("R4 pulse one cycle", {7'd0, rd_rdy_o}, 8'd0);
    addr_i = 8'h10;
    nxt();
  endtask

  task automatic t_back_to_back();
    launch(1'b0, 1'b1, 1'b1);
    nxt();
    launch(1'b0, 1'b0, 1'b1);
    nxt();
    chk("R6 both slots taken", {6'd0, ale_n_o}, 8'd0);
    chk("R5 full wr_rdy low", {7'd0, wr_rdy_o}, 8'd0);
    chk("R8 rdy low when full", {7'd0, rdy_o}, 8'd0);
    chk("R6 oldest served first", {5'd0, io_rd_o, io_uds_o, io_lds_o}, 8'b011);
    launch(1'b1, 1'b1, 1'b1);
    io_act_i = 1'b1;
    nxt();
    start_i = 1'b0;
    chk("R7 full start ignored", {6'd0, ale_n_o}, 8'd1);
    chk("R5 wr_rdy back", {7'd0, wr_rdy_o}, 8'd1);
    io_act_i = 1'b0;
    nxt();
    chk("R9 idle cycle", {7'd0, io_req_o}, 8'd0);
    nxt();
    chk("R6 second request", {7'd0, io_req_o}, 8'd1);
    chk("R6 second fields", {5'd0, io_rd_o, io_uds_o, io_lds_o}, 8'b001);
    io_act_i = 1'b1;
    nxt();
    chk("R3 second slot released", {6'd0, ale_n_o}, 8'd3);
    io_act_i = 1'b0;
    nxt();
    nxt();
    chk("R7 no extra transfer", {7'd0, io_req_o}, 8'd0);
    chk("R4 no pulse after dropped read", {7'd0, rd_rdy_o}, 8'd0);
    launch(1'b0, 1'b1, 1'b1);
    nxt(); start_i = 1'b0;
    chk("R10 empty uses slot0", {6'd0, ale_n_o}, 8'd2);
    io_act_i = 1'b1;
    nxt();
    io_act_i = 1'b0;
    nxt();
    nxt();
  endtask

  initial begin
    t_reset();
    t_single_write();
    t_single_read();
    t_back_to_back();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule